// File: doc/BRIEF.md
# Codeword-Property Signature Monitor

This block watches an instruction stream and flags control-flow errors without keeping any per-block reference signature. Every accepted instruction word is folded into a running signature by XOR. Some words carry a checkpoint mark. At a marked word the monitor checks a fixed property instead of comparing against a stored value: the folded signature must hold exactly `ONES` one-bits out of its `SIG_W` bits, which makes it an m-out-of-n codeword. If it does not, a sticky error flag is raised. After every checkpoint the signature starts again from zero, so each region between checkpoints is checked on its own.

The checkpoint mark travels as a parity-style tag bit beside each word. A word whose tag equals the XOR of its bits is ordinary. A word whose tag differs from that XOR is a checkpoint. Branches that join at a common block are handled in the instruction stream itself. Each predecessor ends with an exit byte, zero-extended to a full word and folded like any other word, whose value is chosen so that the signature becomes a codeword together with the marked first word of the join block. The check on arrival therefore passes whichever predecessor ran.

Top module: `sigmon_top`

## Requirements
- R1: After a synchronous reset, `error_o` is 0 and the signature is all zeros. A first region made only of a marked word with exactly 8 ones therefore passes.
- R2: For each accepted word (`instr_valid_i`=1), the signature becomes its old value XOR the word.
- R3: When `instr_valid_i` is 0, the word and tag inputs have no effect on the signature or on `error_o`.
- R4: An accepted word is a checkpoint exactly when `instr_tag_i` differs from the XOR-reduction of `instr_word_i`. A word whose tag equals that XOR is never checked.
- R5: At an accepted checkpoint, let S be the old signature XOR the marked word. If S does not have exactly 8 ones among its 16 bits, `error_o` is 1 from the clock edge that accepts that word. Weights of 7 and 9 both fail.
- R6: After any accepted checkpoint, whether it passes or fails, the signature is cleared to zero.
- R7: Once `error_o` is 1 it stays 1 until reset, even through later checkpoints that pass.
- R8: An exit byte in the low 8 bits with the upper bits zero is folded like any other word. Two predecessor regions with different signatures, each ending in its own matching exit byte and followed by the same marked join word, both pass. A wrong exit byte fails.
- R9: An unmarked word never raises `error_o`, whatever the weight of the signature.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid_i | input | 1 | Strobe: the word on `instr_word_i` is accepted this cycle |
| instr_word_i | input | SIG_W | Fetched instruction word or zero-extended exit byte |
| instr_tag_i | input | 1 | Parity-style tag; it marks a checkpoint when it differs from the word's XOR |
| error_o | output | 1 | Sticky control-flow error flag |

## Verification
The hardest situation to reach from the ports is the join of two branch paths. It needs two separate regions whose signatures differ. Each must be closed by an exit byte that is exact for that path, and each must then meet the same marked target word. The stimulus builds both paths from fixed words. It computes each exit byte from the path signature and the target word. It then runs one path with the matching byte and one path with a deliberately wrong byte. Weight boundaries of 7 and 9 ones, and the difference between a tag that marks a word and one that does not, are reached by choosing words of known parity and weight.

// File: rtl/sigmon_pkg.sv
package sigmon_pkg;

    localparam int unsigned DEF_SIG_W = 16;
    localparam int unsigned DEF_ONES  = 8;

    typedef enum logic [1:0] {
        VERDICT_IDLE = 2'd0,
        VERDICT_PASS = 2'd1,
        VERDICT_FAIL = 2'd2
    } verdict_e;

    typedef struct packed {
        logic accept;
        logic checkpoint;
    } beat_ctl_t;

    function automatic verdict_e grade(input logic is_chk, input logic weight_ok);
        if (!is_chk)
            return VERDICT_IDLE;
        return weight_ok ? VERDICT_PASS : VERDICT_FAIL;
    endfunction

endpackage

// File: rtl/sigmon_mark_decode.sv
module sigmon_mark_decode
    import sigmon_pkg::*;
#(
    parameter int unsigned SIG_W = DEF_SIG_W
) (
    input  logic             valid_i,
    input  logic [SIG_W-1:0] word_i,
    input  logic             tag_i,
    output beat_ctl_t        ctl_o
);
    logic word_parity;

    always_comb begin
        word_parity    = ^word_i;
        ctl_o.accept     = valid_i;
        ctl_o.checkpoint = valid_i & (tag_i ^ word_parity);
    end

endmodule

// File: rtl/sigmon_sig_accum.sv
module sigmon_sig_accum
    import sigmon_pkg::*;
#(
    parameter int unsigned SIG_W = DEF_SIG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  beat_ctl_t        ctl_i,
    input  logic [SIG_W-1:0] word_i,
    output logic [SIG_W-1:0] folded_o
);
    logic [SIG_W-1:0] sig_q;

    assign folded_o = sig_q ^ word_i;

    always_ff @(posedge clk) begin
        if (rst)
            sig_q <= '0;
        else if (ctl_i.checkpoint)
            sig_q <= '0;
        else if (ctl_i.accept)
            sig_q <= folded_o;
    end

    assert_cleared_after_chk_R6: assert property (@(posedge clk) disable iff (rst)
        ctl_i.checkpoint |=> (sig_q == '0));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !ctl_i.accept |=> $stable(sig_q));

    assert_fold_xor_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.accept && !ctl_i.checkpoint) |=> (sig_q == ($past(sig_q) ^ $past(word_i))));

endmodule

// File: rtl/sigmon_weight_check.sv
module sigmon_weight_check
    import sigmon_pkg::*;
#(
    parameter int unsigned SIG_W = DEF_SIG_W,
    parameter int unsigned ONES  = DEF_ONES
) (
    input  logic [SIG_W-1:0] sig_i,
    output logic             weight_ok_o
);
    localparam int unsigned CW = $clog2(SIG_W + 1);

    logic [CW-1:0] partial [SIG_W+1];

    assign partial[0] = '0;

    for (genvar g = 0; g < SIG_W; g++) begin : g_count
        assign partial[g+1] = partial[g] + CW'(sig_i[g]);
    end

    assign weight_ok_o = (partial[SIG_W] == CW'(ONES));

endmodule

// File: rtl/sigmon_top.sv
module sigmon_top
    import sigmon_pkg::*;
#(
    parameter int unsigned SIG_W = DEF_SIG_W,
    parameter int unsigned ONES  = DEF_ONES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_valid_i,
    input  logic [SIG_W-1:0] instr_word_i,
    input  logic             instr_tag_i,
    output logic             error_o
);
    beat_ctl_t        ctl;
    logic [SIG_W-1:0] folded;
    logic             weight_ok;
    verdict_e         verdict;
    logic             error_q;

    sigmon_mark_decode #(.SIG_W(SIG_W)) u_decode (
        .valid_i (instr_valid_i),
        .word_i  (instr_word_i),
        .tag_i   (instr_tag_i),
        .ctl_o   (ctl)
    );

    sigmon_sig_accum #(.SIG_W(SIG_W)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .ctl_i    (ctl),
        .word_i   (instr_word_i),
        .folded_o (folded)
    );

    sigmon_weight_check #(.SIG_W(SIG_W), .ONES(ONES)) u_check (
        .sig_i       (folded),
        .weight_ok_o (weight_ok)
    );

    assign verdict = grade(ctl.checkpoint, weight_ok);

    always_ff @(posedge clk) begin
        if (rst)
            error_q <= 1'b0;
        else if (verdict == VERDICT_FAIL)
            error_q <= 1'b1;
    end

    assign error_o = error_q;

    assert_sticky_error_R7: assert property (@(posedge clk) disable iff (rst)
        error_q |=> error_q);

    assert_no_err_unmarked_R9: assert property (@(posedge clk) disable iff (rst)
        (!error_q && !ctl.checkpoint) |=> !error_q);

    assert_fail_raises_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl.checkpoint && !weight_ok) |=> error_q);

    assert_pass_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl.checkpoint && weight_ok) |=> (error_q == $past(error_q)));

endmodule

// File: tb/sigmon_top_tb_top.sv
module sigmon_top_tb_top;

    localparam int W = 16;
    localparam int M = 8;

    typedef struct {
        logic  exp_err;
        string req;
    } exp_item_t;

    logic         clk = 1'b0;
    logic         rst;
    logic         valid;
    logic [W-1:0] word;
    logic         tag;
    logic         error_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    exp_item_t    sb_q[$];
    logic [W-1:0] m_sig;
    logic         m_err;

    always #4 clk = ~clk;

    sigmon_top #(.SIG_W(W), .ONES(M)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .instr_valid_i (valid),
        .instr_word_i  (word),
        .instr_tag_i   (tag),
        .error_o       (error_o)
    );

    function automatic int weight(input logic [W-1:0] v);
        int c = 0;
        for (int i = 0; i < W; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: error_o actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; valid = 1'b0; word = '0; tag = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_sig = '0; m_err = 1'b0;
        sb_q.delete();
    endtask

    // mark=1 -> tag set to differ from the word XOR (checkpoint); mark=0 -> tag equals it
    task automatic drive(input logic v, input logic [W-1:0] w, input logic mark, input string req);
        exp_item_t it;
        @(negedge clk);
        valid = v; word = w; tag = mark ^ (^w);
        if (v) begin
            if (mark) begin
                if (weight(m_sig ^ w) != M) m_err = 1'b1;
                m_sig = '0;
            end else begin
                m_sig = m_sig ^ w;
            end
        end
        @(posedge clk);
        #2;
        it.exp_err = m_err;
        it.req     = req;
        sb_q.push_back(it);
    endtask

    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            check(error_o, it.exp_err, it.req);
        end
    end

    task automatic flush();
        @(negedge clk);
        valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [W-1:0] tgt;
        logic [W-1:0] path_sig;
        logic [7:0]   exit_b;
        rst = 1'b1; valid = 1'b0; word = '0; tag = 1'b0;
        do_reset();

        // R1: reset state, then a weight-8 marked word passes on a zero signature
        @(negedge clk);
        check(error_o, 1'b0, "R1 reset");
        drive(1'b1, 16'h00FF, 1'b1, "R1");
        flush();

        // R2: folding by XOR, two regions
        drive(1'b1, 16'h0F00, 1'b0, "R2");
        drive(1'b1, 16'h00F0, 1'b0, "R2");
        drive(1'b1, 16'h0000, 1'b1, "R2 pass 0x0FF0");
        drive(1'b1, 16'h0003, 1'b0, "R2");
        drive(1'b1, 16'h0003, 1'b0, "R2 cancel");
        drive(1'b1, 16'hF00F, 1'b1, "R2 pass");
        flush();

        // R3: strobe low with an all-ones word and any tag is ignored
        drive(1'b0, 16'hFFFF, 1'b1, "R3 idle");
        drive(1'b0, 16'h0001, 1'b0, "R3 idle");
        drive(1'b1, 16'h3C3C, 1'b1, "R3 pass after idle");
        flush();

        // R4 / R9: unmarked words with bad weight raise nothing
        drive(1'b1, 16'h0001, 1'b0, "R9 unmarked w1");
        drive(1'b1, 16'h0002, 1'b0, "R4 tag=parity not checked");
        drive(1'b1, 16'hFFFF, 1'b0, "R9 unmarked");
        // signature now 0xFFFC (14 ones); odd-parity word with tag 0 marks it
        drive(1'b1, 16'h0FFD, 1'b1, "R4 odd word tag0 marked");
        flush();

        // R6: checkpoint clears; 0x00FF then 0xFF00 as separate regions
        drive(1'b1, 16'h00FF, 1'b1, "R6 first");
        drive(1'b1, 16'hFF00, 1'b1, "R6 second region");
        flush();

        // R5 / R7: weight 9 fails, error then stays through a good checkpoint
        drive(1'b1, 16'h01FF, 1'b1, "R5 weight9");
        drive(1'b1, 16'h00FF, 1'b1, "R7 sticky");
        drive(1'b0, 16'h0000, 1'b0, "R7 sticky idle");
        flush();
        do_reset();
        @(negedge clk);
        check(error_o, 1'b0, "R7 reset clears");
        drive(1'b1, 16'h007F, 1'b1, "R5 weight7");
        flush();
        do_reset();

        // R6: a failing checkpoint also clears the signature
        drive(1'b1, 16'h0001, 1'b1, "R6 fail clears");
        do_reset();
        drive(1'b1, 16'hFFFF, 1'b0, "R6 setup");
        drive(1'b1, 16'h0000, 1'b1, "R6 fail");
        drive(1'b1, 16'h0000, 1'b0, "R6");
        flush();
        do_reset();

        // R8: branch join from two predecessors with computed exit bytes
        tgt = 16'hA500;
        path_sig = 16'h1234 ^ tgt;
        exit_b = 8'h00;
        for (int e = 0; e < 256; e++) begin
            if (weight(path_sig ^ {8'h00, 8'(e)}) == M) begin
                exit_b = 8'(e);
                break;
            end
        end
        drive(1'b1, 16'h1234, 1'b0, "R8 path A");
        drive(1'b1, {8'h00, exit_b}, 1'b0, "R8 exit A");
        drive(1'b1, tgt, 1'b1, "R8 join A");
        path_sig = 16'h0C00 ^ tgt;
        for (int e = 0; e < 256; e++) begin
            if (weight(path_sig ^ {8'h00, 8'(e)}) == M) begin
                exit_b = 8'(e);
                break;
            end
        end
        drive(1'b1, 16'h0C00, 1'b0, "R8 path B");
        drive(1'b1, {8'h00, exit_b}, 1'b0, "R8 exit B");
        drive(1'b1, tgt, 1'b1, "R8 join B");
        drive(1'b1, 16'h0C00, 1'b0, "R8 path B bad");
        drive(1'b1, 16'h0000, 1'b0, "R8 wrong exit");
        drive(1'b1, tgt, 1'b1, "R8 join B wrong exit");
        flush();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule